// File: doc/BRIEF.md
# Regulator Power-Mode and Wake Controller

This block is the digital state machine that decides whether an on-chip supply regulator and its serial bus driver are powered. It reads five asynchronous comparator flags: battery above the sense threshold, enable pin level, bus line level, overtemperature and thermal cool-down. It drives the regulator enable, the bus driver enable and the strength select of the enable pin pull-down. It also issues a one-cycle restart request to the reset generator whenever the regulator is switched on.

The machine has five states. `PM_OFF` means no battery and everything off. `PM_ON_PEND` means powered but not yet armed. `PM_ON_ARMED` means powered and armed. `PM_STANDBY` means the regulator is off and the machine is waiting for a wake. `PM_THERMAL` is the overtemperature shutdown. The named transitions are:
- power-up: `PM_OFF` to `PM_ON_PEND`.
- arm: `PM_ON_PEND` to `PM_ON_ARMED`, on enable high.
- sleep: `PM_ON_ARMED` to `PM_STANDBY`, on enable low.
- enable wake: `PM_STANDBY` to `PM_ON_PEND`.
- bus wake: `PM_STANDBY` to `PM_ON_PEND`.
- trip: `PM_ON_PEND` or `PM_ON_ARMED` to `PM_THERMAL`.
- recover: `PM_THERMAL` to `PM_ON_PEND`, on cool-down.
- brown-out: any state to `PM_OFF`.

A bus wake needs the bus level to stay away from the level it had at standby entry for `WAKE_TICKS` ticks of a slow timebase. The slow timebase is the `tick` strobe, for example 1 µs per tick with 45 ticks.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: With the battery flag low the regulator is off. When the synchronized battery flag goes high, the regulator and bus driver turn on in the unarmed state.
- R2: In the unarmed state a low enable level never turns the regulator off.
- R3: In the armed state a low enable level enters standby, where the regulator enable and bus driver enable are both 0.
- R4: `pd_strong` is 1 whenever the regulator is off and 0 whenever it is on.
- R5: In standby, enable high turns the regulator back on in the unarmed state.
- R6: In standby, a bus level that differs from the level at standby entry during `WAKE_TICKS` consecutive ticks turns the regulator on. Fewer ticks do not. Any return to the entry level clears the tick count. Both polarities wake.
- R7: Overtemperature in either powered state turns off the regulator and the bus driver.
- R8: After an overtemperature shutdown the block stays off until the cool-down flag is 1. It then turns on, whatever the enable and bus levels are.
- R9: Loss of the battery flag turns everything off and clears arming, so after the battery returns a low enable does not turn the regulator off.
- R10: Each switch-on of the regulator gives exactly one `rst_req` pulse, one clock long. No pulse is given otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timebase strobe for the bus wake filter, synchronous to clk |
| batt_ok_a | input | 1 | Battery above sense threshold (asynchronous) |
| en_pin_a | input | 1 | Enable pin level (asynchronous) |
| bus_lvl_a | input | 1 | Bus line level (asynchronous) |
| ovt_a | input | 1 | Overtemperature flag (asynchronous) |
| cool_a | input | 1 | Cool-down temperature reached (asynchronous) |
| reg_en | output | 1 | Regulator enable |
| bus_drv_en | output | 1 | Bus driver enable |
| pd_strong | output | 1 | 1 selects the strong enable pull-down, 0 the weak one |
| rst_req | output | 1 | One-cycle restart request to the reset generator |

## Verification
The hardest case to reach is a bus wake that sits exactly on the filter boundary, together with a wake that is aborted midway. The bench parks the machine in standby through arm and sleep, and holds the tick strobe idle. It then moves the bus level and issues an exact number of tick pulses by hand, sweeping that number from one to one past `WAKE_TICKS` for both bus polarities. A further run breaks a sub-threshold excursion with a return to the entry level, to show that the count restarts.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_OFF      = 3'd0,
        PM_ON_PEND  = 3'd1,
        PM_ON_ARMED = 3'd2,
        PM_STANDBY  = 3'd3,
        PM_THERMAL  = 3'd4
    } pm_state_e;

    localparam int unsigned PMC_NUM_FLAGS = 5;
    localparam int unsigned PMC_IDX_BATT  = 0;
    localparam int unsigned PMC_IDX_EN    = 1;
    localparam int unsigned PMC_IDX_BUS   = 2;
    localparam int unsigned PMC_IDX_OVT   = 3;
    localparam int unsigned PMC_IDX_COOL  = 4;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_bus_wake.sv
module pmc_bus_wake #(
    parameter int unsigned WAKE_TICKS = 45,
    localparam int unsigned CNT_W = (WAKE_TICKS < 2) ? 1 : $clog2(WAKE_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic watch_i,
    input  logic bus_i,
    output logic wake_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_TICKS - 1);

    logic             ref_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wake_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            cnt_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            if (!watch_i) begin
                ref_q <= bus_i;
                cnt_q <= '0;
            end else if (bus_i == ref_q) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q == LAST) begin
                    wake_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign wake_o = wake_q;

    // R6: the count never passes the last tick index
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R6: a wake is only raised on a tick edge
    p_wake_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(tick_i) && $past(watch_i));

    // R6: a return to the entry level clears the count
    p_return_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_i && bus_i == ref_q) |=> cnt_q == '0);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic batt_i,
    input  logic en_i,
    input  logic ovt_i,
    input  logic cool_i,
    input  logic wake_i,
    output logic standby_o,
    output logic reg_en_o,
    output logic bus_drv_en_o,
    output logic pd_strong_o,
    output logic rst_req_o
);
    pm_state_e st_q, st_d;
    logic      rst_req_q;
    logic      powered_q;

    always_comb begin
        st_d = st_q;
        if (!batt_i) begin
            st_d = PM_OFF;
        end else begin
            unique case (st_q)
                PM_OFF:      st_d = PM_ON_PEND;
                PM_ON_PEND:  if (ovt_i) st_d = PM_THERMAL;
                             else if (en_i) st_d = PM_ON_ARMED;
                PM_ON_ARMED: if (ovt_i) st_d = PM_THERMAL;
                             else if (!en_i) st_d = PM_STANDBY;
                PM_STANDBY:  if (en_i || wake_i) st_d = PM_ON_PEND;
                PM_THERMAL:  if (cool_i) st_d = PM_ON_PEND;
                default:     st_d = PM_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= PM_OFF;
            rst_req_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            rst_req_q <= (st_d == PM_ON_PEND) &&
                         (st_q != PM_ON_PEND) && (st_q != PM_ON_ARMED);
        end
    end

    always_comb begin
        powered_q    = 1'b0;
        standby_o    = 1'b0;
        unique case (st_q)
            PM_OFF:      powered_q = 1'b0;
            PM_ON_PEND:  powered_q = 1'b1;
            PM_ON_ARMED: powered_q = 1'b1;
            PM_STANDBY:  standby_o = 1'b1;
            PM_THERMAL:  powered_q = 1'b0;
            default:     powered_q = 1'b0;
        endcase
        reg_en_o     = powered_q;
        bus_drv_en_o = powered_q;
        pd_strong_o  = !powered_q;
    end

    assign rst_req_o = rst_req_q;

    // R9: battery loss forces the regulator off on the next edge
    p_batt_loss_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_i |=> !reg_en_o && st_q == PM_OFF);

    // R2: unarmed with enable low stays powered
    p_unarmed_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_ON_PEND && batt_i && !en_i && !ovt_i) |=> reg_en_o);

    // R7: overtemperature while powered shuts down
    p_ovt_shutdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en_o && batt_i && ovt_i) |=> !reg_en_o && !bus_drv_en_o);

    // R8: thermal state is left only through cool-down
    p_thermal_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_THERMAL && batt_i && !cool_i) |=> st_q == PM_THERMAL);

    // R10: restart request is a single-cycle pulse
    p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R10: the pulse follows a switch-on
    p_rst_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> reg_en_o && !$past(reg_en_o));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned WAKE_TICKS  = 45,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic batt_ok_a,
    input  logic en_pin_a,
    input  logic bus_lvl_a,
    input  logic ovt_a,
    input  logic cool_a,
    output logic reg_en,
    output logic bus_drv_en,
    output logic pd_strong,
    output logic rst_req
);
    logic [PMC_NUM_FLAGS-1:0] flags_a;
    logic [PMC_NUM_FLAGS-1:0] flags_s;
    logic                     standby;
    logic                     wake;

    always_comb begin
        flags_a                = '0;
        flags_a[PMC_IDX_BATT]  = batt_ok_a;
        flags_a[PMC_IDX_EN]    = en_pin_a;
        flags_a[PMC_IDX_BUS]   = bus_lvl_a;
        flags_a[PMC_IDX_OVT]   = ovt_a;
        flags_a[PMC_IDX_COOL]  = cool_a;
    end

    pmc_sync #(
        .WIDTH  (PMC_NUM_FLAGS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_a),
        .sync_o  (flags_s)
    );

    pmc_bus_wake #(
        .WAKE_TICKS (WAKE_TICKS)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .watch_i (standby),
        .bus_i   (flags_s[PMC_IDX_BUS]),
        .wake_o  (wake)
    );

    pmc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .batt_i       (flags_s[PMC_IDX_BATT]),
        .en_i         (flags_s[PMC_IDX_EN]),
        .ovt_i        (flags_s[PMC_IDX_OVT]),
        .cool_i       (flags_s[PMC_IDX_COOL]),
        .wake_i       (wake),
        .standby_o    (standby),
        .reg_en_o     (reg_en),
        .bus_drv_en_o (bus_drv_en),
        .pd_strong_o  (pd_strong),
        .rst_req_o    (rst_req)
    );

    // R4: pull-down strength is the inverse of the regulator enable at the ports
    p_pd_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_strong != reg_en);

    // R3: the bus driver is never on while the regulator is off
    p_drv_needs_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drv_en |-> reg_en);
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
    localparam int unsigned WT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic batt = 1'b0, en = 1'b0, bus = 1'b0, ovt = 1'b0, cool = 1'b0;
    logic reg_en, bus_drv_en, pd_strong, rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.WAKE_TICKS(WT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .batt_ok_a(batt), .en_pin_a(en), .bus_lvl_a(bus),
        .ovt_a(ovt), .cool_a(cool),
        .reg_en(reg_en), .bus_drv_en(bus_drv_en),
        .pd_strong(pd_strong), .rst_req(rst_req)
    );

    always @(posedge clk) if (rst_n && rst_req) pulses <= pulses + 1;

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic to_standby();
        en = 1'b1; settle(8);
        en = 1'b0; settle(8);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        int p0;
        settle(3);
        rst_n = 1'b1;
        settle(4);
        // R4 reset state: all off, strong pull-down
        chk(reg_en, 1'b0, "R1 reset reg_en");
        chk(pd_strong, 1'b1, "R4 reset pd_strong");
        chk_int(pulses, 0, "R10 no pulse at reset");

        // R1 auto power-on
        batt = 1'b1; settle(8);
        chk(reg_en, 1'b1, "R1 power-on reg_en");
        chk(bus_drv_en, 1'b1, "R1 power-on bus_drv_en");
        chk(pd_strong, 1'b0, "R4 weak pull-down when on");
        chk_int(pulses, 1, "R10 pulse on power-on");

        // R2 unarmed: enable low ignored
        settle(20);
        chk(reg_en, 1'b1, "R2 unarmed stays on");

        // R3 arm then sleep
        to_standby();
        chk(reg_en, 1'b0, "R3 standby reg_en");
        chk(bus_drv_en, 1'b0, "R3 standby bus_drv_en");
        chk(pd_strong, 1'b1, "R4 strong pull-down in standby");

        // R5 enable wake
        en = 1'b1; settle(8);
        chk(reg_en, 1'b1, "R5 enable wake");
        chk_int(pulses, 2, "R10 pulse on enable wake");
        en = 1'b0; settle(8);
        chk(reg_en, 1'b0, "R3 re-enter standby");

        // R6 sweep, both polarities of entry level
        for (int pol = 0; pol < 2; pol++) begin
            for (int n = 1; n <= WT + 1; n++) begin
                p0 = pulses;
                bus = ~bus; settle(4);
                ticks(n);
                bus = ~bus; settle(6);
                chk(reg_en, (n >= WT), $sformatf("R6 pol=%0d ticks=%0d", pol, n));
                chk_int(pulses - p0, (n >= WT) ? 1 : 0, "R10 pulse on bus wake");
                if (n >= WT) to_standby();
            end
            // change entry level while powered, then sleep with the other level
            en = 1'b1; settle(8);
            bus = ~bus; settle(4);
            en = 1'b0; settle(8);
        end

        // R6 a return to the entry level clears the count
        bus = ~bus; settle(4); ticks(WT - 1);
        bus = ~bus; settle(4);
        bus = ~bus; settle(4); ticks(WT - 1);
        bus = ~bus; settle(6);
        chk(reg_en, 1'b0, "R6 interrupted excursion clears count");
        en = 1'b1; settle(8);

        // R7 thermal shutdown from armed state
        cool = 1'b0; ovt = 1'b1; settle(8);
        chk(reg_en, 1'b0, "R7 ovt reg_en");
        chk(bus_drv_en, 1'b0, "R7 ovt bus_drv_en");
        ovt = 1'b0; en = 1'b0; bus = ~bus; settle(10);
        chk(reg_en, 1'b0, "R8 waits for cool-down");
        p0 = pulses;
        cool = 1'b1; settle(8);
        chk(reg_en, 1'b1, "R8 restart regardless of enable and bus");
        chk_int(pulses - p0, 1, "R10 pulse on thermal restart");

        // R9 battery loss clears arming
        en = 1'b1; settle(8);
        batt = 1'b0; settle(8);
        chk(reg_en, 1'b0, "R9 battery loss off");
        chk(pd_strong, 1'b1, "R4 strong pull-down when off");
        en = 1'b0; batt = 1'b1; settle(24);
        chk(reg_en, 1'b1, "R9 arming cleared after battery return");

        done = 1'b1;
        summary();
    end
endmodule